// File: doc/BRIEF.md
# Two-Level Vectoring Interrupt Controller

This block collects interrupt requests from two groups of local sources and one bank of mappable sources, and turns them into one resolved vector for the processor. Each local group has its own enable mask. The mappable bank is shared. Two separate mapped masks filter it, and each filtered result feeds one cascade bit: one in local group 0 and one in local group 1. Six processor-level lines are formed from the groups and from four direct inputs: a processor timer, a bus-error line and two counter-timer lines. These lines are resolved in a fixed order that does not follow their numbers.

Software programs the four mask registers through a simple write/read register port. The same port lets software read the effective group status, the mappable status and the summary of processor lines. The result is a registered level output: a 6-bit vector, a 2-bit source class and a valid flag. There is no handshake and no back-pressure. The vector follows the sources, one cycle behind. A consumer samples it whenever valid is high. A consumer that is slow simply sees the current winner, because nothing is queued or latched.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset all four mask registers read as zero and `irq_valid_o` is low; with only masked group sources active, the output stays invalid.
- R2: A group source is pending only when both its status bit and its mask bit are set. The group's processor line is the OR of its pending bits.
- R3: Within any 8-bit pending set, the highest-numbered set bit wins.
- R4: Bit 7 of each group's effective status is its cascade bit. It is the raw input bit 7 ORed with the OR of (mappable status AND that group's mapped mask). Group 0 uses mapped mask 0 and group 1 uses mapped mask 1.
- R5: When a group's cascade bit is pending, the group resolves from its masked mappable set (base 16 for group 0, base 24 for group 1). Otherwise it resolves from its own pending bits (base 0 for group 0, base 8 for group 1).
- R6: Class codes are 0 = local, 1 = processor timer (vector 7), 2 = bus error (vector 6), 3 = counter-timer (vector 4 for counter 0, vector 5 for counter 1).
- R7: Lines are taken in the order: timer, group 0, group 1, bus error, counter 0, counter 1.
- R8: If group 0 is taken but its chosen set is empty, the output is local vector 0 and valid. If group 1 is taken with an empty set, valid is low, even when lower lines are pending.
- R9: Register addresses: 0 = group 0 mask, 1 = group 1 mask, 2 = mapped mask 0, 3 = mapped mask 1 (read/write, a write lands on the next edge); 4 = group 0 effective status, 5 = group 1 effective status, 6 = mappable status, 7 = line summary (bit n = line n pending for n = 2 to 7; bits 1:0 read zero). Writes to 4 to 7 are ignored. Reads are combinational.
- R10: The output reflects the inputs of the previous cycle. A source that drops stops being reported, with nothing sticky.
- R11: While valid is low, the vector and the class are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| grp0_stat_i | input | 8 | Local group 0 status levels |
| grp1_stat_i | input | 8 | Local group 1 status levels |
| map_stat_i | input | 8 | Shared mappable status levels |
| cpu_timer_i | input | 1 | Processor timer request (line 7) |
| buserr_i | input | 1 | Bus-error request (line 6) |
| ctr0_i | input | 1 | Counter-timer 0 request (line 4) |
| ctr1_i | input | 1 | Counter-timer 1 request (line 5) |
| irq_valid_o | output | 1 | A resolved vector is present |
| irq_vector_o | output | 6 | Resolved vector number |
| irq_class_o | output | 2 | Source class of the vector |

## Verification
The bench goes after the places where the cascade and the fixed order can go wrong. One case is a raw cascade pin with no mapped source behind it. Group 0 must then fall back to vector 0. Group 1 must go silent and must not drop through to bus error. Another case is a mapped source enabled only in the other group's mapped mask. This catches a design that shares one mapped mask between both groups: it would route the source into the wrong group or into both. Bus error pending alongside group 1 checks the order, since a design that sorts by line number would report bus error. Writes to the status addresses check the read-only views, since a design that decodes only the low address bits would overwrite a mask.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic [1:0] {
    CLS_LOCAL   = 2'd0,
    CLS_TIMER   = 2'd1,
    CLS_BUSERR  = 2'd2,
    CLS_COUNTER = 2'd3
  } src_class_e;

  // processor line numbers; these double as the vector of non-local classes
  localparam int LINE_GRP0   = 2;
  localparam int LINE_GRP1   = 3;
  localparam int LINE_CTR0   = 4;
  localparam int LINE_CTR1   = 5;
  localparam int LINE_BUSERR = 6;
  localparam int LINE_TIMER  = 7;

  // number of mask registers and address width of the register port
  localparam int NUM_MASKS = 4;
  localparam int ADDR_W    = 3;
endpackage

// File: rtl/cic_prienc.sv
// Highest-index-wins priority encoder.
module cic_prienc #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/cic_group.sv
// One local group with its cascaded view of the shared mappable bank.
module cic_group #(
  parameter int W         = 8,
  parameter int CASC_BIT  = W - 1,
  parameter int LOC_BASE  = 0,
  parameter int MAP_BASE  = 2 * W,
  parameter int VEC_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     stat_i,
  input  logic [W-1:0]     mask_i,
  input  logic [W-1:0]     map_stat_i,
  input  logic [W-1:0]     map_mask_i,
  output logic [W-1:0]     eff_stat_o,
  output logic             line_o,
  output logic             found_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int IDX_W = $clog2(W);

  logic [W-1:0]     map_sel;
  logic [W-1:0]     pend;
  logic             casc_sum;
  logic [IDX_W-1:0] loc_idx, map_idx;
  logic             loc_any, map_any;

  assign map_sel  = map_stat_i & map_mask_i;
  assign casc_sum = |map_sel;

  always_comb begin
    eff_stat_o           = stat_i;
    eff_stat_o[CASC_BIT] = stat_i[CASC_BIT] | casc_sum;
  end

  assign pend   = eff_stat_o & mask_i;
  assign line_o = |pend;

  cic_prienc #(.W(W)) u_loc_enc (.req_i(pend),    .idx_o(loc_idx), .any_o(loc_any));
  cic_prienc #(.W(W)) u_map_enc (.req_i(map_sel), .idx_o(map_idx), .any_o(map_any));

  always_comb begin
    if (pend[CASC_BIT]) begin
      found_o = map_any;
      vec_o   = VEC_W'(MAP_BASE) + VEC_W'(map_idx);
    end else begin
      found_o = loc_any;
      vec_o   = VEC_W'(LOC_BASE) + VEC_W'(loc_idx);
    end
  end

  // R5: the mapped range is chosen exactly when the cascade bit is pending
  p_map_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (found_o && pend[CASC_BIT]) |-> (vec_o >= VEC_W'(MAP_BASE)));
  // R3: the reported mapped source really is active and selected
  p_map_src_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (found_o && pend[CASC_BIT]) |-> map_sel[IDX_W'(vec_o - VEC_W'(MAP_BASE))]);
endmodule

// File: rtl/cic_regs.sv
// Mask registers and read-back multiplexer.
module cic_regs
  import cic_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [W-1:0]                wdata_i,
  input  logic [W-1:0]                eff0_i,
  input  logic [W-1:0]                eff1_i,
  input  logic [W-1:0]                map_stat_i,
  input  logic [W-1:0]                lines_i,
  output logic [NUM_MASKS-1:0][W-1:0] mask_o,
  output logic [W-1:0]                rdata_o
);
  logic [NUM_MASKS-1:0][W-1:0] mask_q;
  logic                        is_mask_addr;

  assign is_mask_addr = (addr_i < ADDR_W'(NUM_MASKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en_i && is_mask_addr) begin
      mask_q[addr_i[1:0]] <= wdata_i;
    end
  end

  assign mask_o = mask_q;

  always_comb begin
    unique case (addr_i)
      3'd0, 3'd1, 3'd2, 3'd3: rdata_o = mask_q[addr_i[1:0]];
      3'd4:    rdata_o = eff0_i;
      3'd5:    rdata_o = eff1_i;
      3'd6:    rdata_o = map_stat_i;
      default: rdata_o = lines_i;
    endcase
  end

  // R9: a mask write is visible after the next edge
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && is_mask_addr) |=> (mask_q[$past(addr_i[1:0])] == $past(wdata_i)));
  // R9: writes to status views leave every mask untouched
  p_ro_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !is_mask_addr) |=> $stable(mask_q));
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
#(
  parameter int W        = 8,
  parameter int CASC_BIT = W - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr_en,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [W-1:0]              reg_wdata,
  output logic [W-1:0]              reg_rdata,
  input  logic [W-1:0]              grp0_stat_i,
  input  logic [W-1:0]              grp1_stat_i,
  input  logic [W-1:0]              map_stat_i,
  input  logic                      cpu_timer_i,
  input  logic                      buserr_i,
  input  logic                      ctr0_i,
  input  logic                      ctr1_i,
  output logic                      irq_valid_o,
  output logic [$clog2(4*W):0]      irq_vector_o,
  output logic [1:0]                irq_class_o
);
  localparam int VEC_W  = $clog2(4 * W) + 1;
  localparam int NGRP   = 2;

  logic [NUM_MASKS-1:0][W-1:0] mask;
  logic [NGRP-1:0][W-1:0]      grp_stat, eff;
  logic [NGRP-1:0]             gline, gfound;
  logic [NGRP-1:0][VEC_W-1:0]  gvec;
  logic [W-1:0]                lines;

  assign grp_stat[0] = grp0_stat_i;
  assign grp_stat[1] = grp1_stat_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    cic_group #(
      .W(W), .CASC_BIT(CASC_BIT), .LOC_BASE(g * W),
      .MAP_BASE((2 + g) * W), .VEC_W(VEC_W)
    ) u_grp (
      .clk(clk), .rst_n(rst_n),
      .stat_i(grp_stat[g]), .mask_i(mask[g]),
      .map_stat_i(map_stat_i), .map_mask_i(mask[2 + g]),
      .eff_stat_o(eff[g]), .line_o(gline[g]),
      .found_o(gfound[g]), .vec_o(gvec[g])
    );
  end

  always_comb begin
    lines              = '0;
    lines[LINE_GRP0]   = gline[0];
    lines[LINE_GRP1]   = gline[1];
    lines[LINE_CTR0]   = ctr0_i;
    lines[LINE_CTR1]   = ctr1_i;
    lines[LINE_BUSERR] = buserr_i;
    lines[LINE_TIMER]  = cpu_timer_i;
  end

  cic_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(reg_wr_en), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .eff0_i(eff[0]), .eff1_i(eff[1]), .map_stat_i(map_stat_i),
    .lines_i(lines), .mask_o(mask), .rdata_o(reg_rdata)
  );

  // fixed-order line resolution
  logic             nx_valid;
  logic [VEC_W-1:0] nx_vec;
  src_class_e       nx_cls;

  always_comb begin
    nx_valid = 1'b0;
    nx_vec   = '0;
    nx_cls   = CLS_LOCAL;
    if (cpu_timer_i) begin
      nx_valid = 1'b1; nx_cls = CLS_TIMER;  nx_vec = VEC_W'(LINE_TIMER);
    end else if (gline[0]) begin
      nx_valid = 1'b1;
      nx_vec   = gfound[0] ? gvec[0] : '0;
    end else if (gline[1]) begin
      nx_valid = gfound[1];
      nx_vec   = gfound[1] ? gvec[1] : '0;
    end else if (buserr_i) begin
      nx_valid = 1'b1; nx_cls = CLS_BUSERR; nx_vec = VEC_W'(LINE_BUSERR);
    end else if (ctr0_i) begin
      nx_valid = 1'b1; nx_cls = CLS_COUNTER; nx_vec = VEC_W'(LINE_CTR0);
    end else if (ctr1_i) begin
      nx_valid = 1'b1; nx_cls = CLS_COUNTER; nx_vec = VEC_W'(LINE_CTR1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid_o  <= 1'b0;
      irq_vector_o <= '0;
      irq_class_o  <= CLS_LOCAL;
    end else begin
      irq_valid_o  <= nx_valid;
      irq_vector_o <= nx_vec;
      irq_class_o  <= nx_cls;
    end
  end

  // R7: the processor timer beats every other line
  p_timer_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_timer_i |=> (irq_valid_o && irq_class_o == CLS_TIMER
                     && irq_vector_o == VEC_W'(LINE_TIMER)));
  // R11: an idle output carries no stale vector
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid_o |-> (irq_vector_o == '0 && irq_class_o == CLS_LOCAL));
  // R6: non-local classes carry a line number 4..7
  p_nonlocal_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_class_o != CLS_LOCAL) |->
      (irq_vector_o >= VEC_W'(LINE_CTR0) && irq_vector_o <= VEC_W'(LINE_TIMER)));
  // R10: with every source quiet, nothing is reported next cycle
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_timer_i && !buserr_i && !ctr0_i && !ctr1_i && grp0_stat_i == '0
     && grp1_stat_i == '0 && map_stat_i == '0) |=> !irq_valid_o);
endmodule

// File: tb/cascade_irq_ctrl_tb_top.sv
module cascade_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] g0 = '0, g1 = '0, ms = '0;
  logic       tmr = 1'b0, be = 1'b0, c0 = 1'b0, c1 = 1'b0;
  logic       irq_valid_o;
  logic [5:0] irq_vector_o;
  logic [1:0] irq_class_o;

  int total = 0, bad = 0;
  bit finished = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  cascade_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grp0_stat_i(g0),
    .grp1_stat_i(g1), .map_stat_i(ms), .cpu_timer_i(tmr), .buserr_i(be),
    .ctr0_i(c0), .ctr1_i(c1), .irq_valid_o(irq_valid_o),
    .irq_vector_o(irq_vector_o), .irq_class_o(irq_class_o)
  );

  // ---------------- behavioural reference ----------------
  int    mk[4];
  int    ev = 0, evec = 0, ecls = 0;
  string etag = "R11";

  function automatic int top_bit(int v);
    for (int i = 7; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int eff_of(int raw, int sel);
    return (sel != 0) ? (raw | 8'h80) : raw;
  endfunction

  function automatic int line_sum();
    int p0, p1;
    p0 = eff_of(g0, ms & mk[2]) & mk[0];
    p1 = eff_of(g1, ms & mk[3]) & mk[1];
    return ((p0 != 0) << 2) | ((p1 != 0) << 3) | (int'(c0) << 4) |
           (int'(c1) << 5) | (int'(be) << 6) | (int'(tmr) << 7);
  endfunction

  function automatic int exp_rdata(int a);
    case (a)
      0, 1, 2, 3: return mk[a];
      4: return eff_of(g0, ms & mk[2]);
      5: return eff_of(g1, ms & mk[3]);
      6: return ms;
      default: return line_sum();
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mk[i]) mk[i] = 0;
      ev = 0; evec = 0; ecls = 0; etag = "R1";
    end else begin
      int s0, s1, p0, p1, b;
      s0 = ms & mk[2]; s1 = ms & mk[3];
      p0 = eff_of(g0, s0) & mk[0];
      p1 = eff_of(g1, s1) & mk[1];
      ev = 0; evec = 0; ecls = 0; etag = "R11";
      if (tmr) begin
        ev = 1; evec = 7; ecls = 1; etag = "R7";
      end else if (p0 != 0) begin
        ev = 1;
        if (p0[7]) begin
          b = top_bit(s0);
          if (b < 0) begin evec = 0; etag = "R8"; end
          else begin evec = 16 + b; etag = "R5"; end
        end else begin evec = top_bit(p0); etag = "R3"; end
      end else if (p1 != 0) begin
        if (p1[7]) begin
          b = top_bit(s1);
          if (b < 0) etag = "R8";
          else begin ev = 1; evec = 24 + b; etag = "R5"; end
        end else begin ev = 1; evec = 8 + top_bit(p1); etag = "R3"; end
      end else if (be) begin
        ev = 1; evec = 6; ecls = 2; etag = "R6";
      end else if (c0) begin
        ev = 1; evec = 4; ecls = 3; etag = "R7";
      end else if (c1) begin
        ev = 1; evec = 5; ecls = 3; etag = "R6";
      end
      if (reg_wr_en && reg_addr < 4) mk[reg_addr] = int'(reg_wdata);
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int er;
      total++;
      if (irq_valid_o !== ev[0] || irq_vector_o !== 6'(evec) || irq_class_o !== 2'(ecls)) begin
        bad++;
        $display("FAIL %s/%s output: got v=%0b vec=%0d cls=%0d exp v=%0d vec=%0d cls=%0d",
                 phase, etag, irq_valid_o, irq_vector_o, irq_class_o, ev, evec, ecls);
      end
      er = exp_rdata(int'(reg_addr));
      total++;
      if (reg_rdata !== 8'(er)) begin
        bad++;
        $display("FAIL R9 (%s) rdata addr=%0d: got %02h exp %02h",
                 phase, reg_addr, reg_rdata, er[7:0]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    reg_wr_en = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic src(int a, int b, int m, bit t, bit e, bit x0, bit x1);
    g0 = 8'(a); g1 = 8'(b); ms = 8'(m); tmr = t; be = e; c0 = x0; c1 = x1;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1: masks zero after reset, group sources blocked
    phase = "R1";
    src(8'hFF, 8'hFF, 8'hFF, 0, 0, 0, 0);
    for (int a = 0; a < 8; a++) begin reg_addr = 3'(a); step(); end
    // R9: program masks and read them back; status writes ignored
    phase = "R9";
    src(0, 0, 0, 0, 0, 0, 0);
    wr(0, 8'h5A); wr(1, 8'hA5); wr(2, 8'h0F); wr(3, 8'hF0);
    wr(4, 8'hFF); wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
    for (int a = 0; a < 8; a++) begin reg_addr = 3'(a); step(); end
    // R2: only masked-in status bits count
    phase = "R2";
    wr(0, 8'h06); wr(1, 8'h00);
    src(8'hF9, 8'hFF, 0, 0, 0, 0, 0); step(2);
    src(8'h0C, 0, 0, 0, 0, 0, 0); step(2);
    // R4: mapped source enabled only for group 1 feeds group 1 only
    phase = "R4";
    wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h01); wr(3, 8'h22);
    reg_addr = 3'd4;
    src(0, 0, 8'h20, 0, 0, 0, 0); step(2);
    reg_addr = 3'd5; step();
    src(0, 0, 8'h21, 0, 0, 0, 0); step(2);
    // R8: raw cascade pin with no mapped source
    phase = "R8";
    wr(2, 0); wr(3, 0);
    src(8'h80, 0, 8'hFF, 0, 0, 0, 0); step(2);
    src(0, 8'h80, 8'hFF, 0, 1, 1, 1); step(2);
    // R6 / R7: direct lines and their order
    phase = "R6";
    wr(0, 0); wr(1, 0);
    src(0, 0, 0, 0, 1, 1, 1); step();
    src(0, 0, 0, 0, 0, 1, 1); step();
    src(0, 0, 0, 0, 0, 0, 1); step();
    phase = "R7";
    wr(1, 8'h10);
    src(0, 8'h10, 0, 0, 1, 0, 0); step();
    src(0, 8'h10, 0, 1, 1, 0, 0); step();
    // R10: a one-cycle pulse is reported once then dropped
    phase = "R10";
    src(0, 0, 0, 0, 1, 0, 0); step();
    src(0, 0, 0, 0, 0, 0, 0); step(3);
    // R5 / R3 random mix
    phase = "R5";
    for (int n = 0; n < 3000; n++) begin
      reg_wr_en = ($urandom % 4 == 0);
      reg_addr  = 3'($urandom);
      reg_wdata = 8'($urandom);
      g0  = 8'($urandom & $urandom);
      g1  = 8'($urandom & $urandom);
      ms  = 8'($urandom & $urandom);
      tmr = ($urandom % 10 == 0);
      be  = ($urandom % 3 == 0);
      c0  = ($urandom % 3 == 0);
      c1  = ($urandom % 3 == 0);
      step();
    end
    reg_wr_en = 1'b0;
    step(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule